// File: doc/BRIEF.md
# Double-Precision Compare, Min/Max and Sign-Injection Unit

This unit carries out the non-arithmetic operations on two 64-bit IEEE-754 double-precision operands that an FPU sends around its adders and multipliers. It produces ordered comparisons with a 1-bit answer, a minimum and a maximum that follow the minNum/maxNum treatment of NaN, and three sign-injection forms that change only the sign bit.

A caller presents both operands and a 3-bit operation code and pulses a valid strobe. One clock later the unit raises a done strobe for one cycle. With it come the 64-bit result and a 5-bit exception-flag vector. No operation stalls, so a new request may be accepted on every cycle. The result and flags keep their last values until the next accepted request.

Top module: `fpd_cmsj_unit`

## Requirements
- R1: `done_o` is high in exactly the cycle after a cycle with `req_valid_i` high. `res_o` and `fflags_o` are registered on that same edge, and both hold their values while no request is accepted. Reset clears all outputs to zero.
- R2: Operation codes are 0 equal, 1 less-than, 2 less-or-equal, 3 minimum, 4 maximum, 5 sign-copy, 6 sign-copy-negated and 7 sign-XOR. A compare returns its answer in bit 0, and bits 63:1 are zero.
- R3: For ordered non-NaN operands, equal, less-than and less-or-equal follow numeric order. This includes negative values, where a larger magnitude is the smaller number.
- R4: Infinities of the same sign compare as equal. +0 and -0 compare as equal, and neither is less than the other.
- R5: A NaN is an operand with exponent field all ones and a non-zero fraction. It is signaling when fraction bit 51 is 0. Every compare with a NaN operand returns 0. Equal raises invalid only for a signaling NaN. Less-than and less-or-equal raise invalid for any NaN.
- R6: For two non-NaN operands, minimum returns the smaller and maximum returns the larger, and neither raises a flag.
- R7: When exactly one operand of minimum or maximum is a NaN, the result is the other operand. A quiet NaN raises no flag. A signaling NaN raises invalid.
- R8: When both operands of minimum or maximum are NaN, the result is 0x7FF8000000000000.
- R9: Minimum and maximum order -0 below +0: min(+0,-0) is -0 and max(-0,+0) is +0.
- R10: Sign-copy places the sign of operand B on bits 62:0 of operand A. Sign-copy-negated uses the inverted sign of B. Sign-XOR uses the XOR of both signs. Bits 62:0 pass unchanged, even for NaN, and no flag is raised.
- R11: The flag vector is {invalid, divide-by-zero, overflow, underflow, inexact}, with invalid in bit 4. Bits 3:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| op_sel_i | input | 3 | Operation code (R2) |
| opnd_a_i | input | 64 | Operand A |
| opnd_b_i | input | 64 | Operand B |
| done_o | output | 1 | Result strobe, one cycle after the request |
| res_o | output | 64 | Registered result |
| fflags_o | output | 5 | Registered exception flags |

## Verification
The compares are driven with three kinds of pairs: equal pairs, pairs with a smaller negative first operand, and mixed-sign pairs. Together these separate a signed ordering from a plain magnitude test. Same-sign infinities and the two zeros show whether equality is judged numerically or by raw bits. Quiet and signaling NaNs on either side test the masking of the answer and which compares raise invalid. Minimum and maximum are tried with finite values, with one NaN, with two NaNs and with zeros of opposite sign, and the sign-injection forms use a signaling-NaN payload to show that bits 62:0 pass through untouched.

// File: rtl/fpd_cmsj_pkg.sv
package fpd_cmsj_pkg;
    localparam int unsigned EXP_W  = 11;
    localparam int unsigned MAN_W  = 52;
    localparam int unsigned FP_W   = 1 + EXP_W + MAN_W;
    localparam int unsigned FLAG_W = 5;
    localparam int unsigned NV_BIT = FLAG_W - 1;

    typedef enum logic [2:0] {
        OP_EQ    = 3'd0,
        OP_LT    = 3'd1,
        OP_LE    = 3'd2,
        OP_MIN   = 3'd3,
        OP_MAX   = 3'd4,
        OP_SGN   = 3'd5,
        OP_SGNN  = 3'd6,
        OP_SGNX  = 3'd7
    } fpd_op_e;

    typedef struct packed {
        logic              done;
        logic [FP_W-1:0]   res;
        logic [FLAG_W-1:0] flags;
    } fpd_out_t;

    typedef struct packed {
        logic                    sign;
        logic [FP_W-2:0]         mag;
        logic                    is_nan;
        logic                    is_snan;
        logic                    is_zero;
    } fpd_cls_t;

    localparam logic [FP_W-1:0] CANON_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
endpackage

// File: rtl/fpd_classify.sv
module fpd_classify
    import fpd_cmsj_pkg::*;
#(
    parameter int unsigned E_W = EXP_W,
    parameter int unsigned M_W = MAN_W
) (
    input  logic [E_W+M_W:0] val_i,
    output fpd_cls_t         cls_o
);
    logic [E_W-1:0] expo;
    logic [M_W-1:0] frac;

    always_comb begin
        expo          = val_i[E_W+M_W-1:M_W];
        frac          = val_i[M_W-1:0];
        cls_o.sign    = val_i[E_W+M_W];
        cls_o.mag     = val_i[E_W+M_W-1:0];
        cls_o.is_nan  = (&expo) && (|frac);
        cls_o.is_snan = (&expo) && (|frac) && !frac[M_W-1];
        cls_o.is_zero = (expo == '0) && (frac == '0);
    end
endmodule

// File: rtl/fpd_order.sv
module fpd_order
    import fpd_cmsj_pkg::*;
(
    input  fpd_cls_t a_i,
    input  fpd_cls_t b_i,
    output logic     eq_o,
    output logic     lt_o,
    output logic     lt_signed_zero_o
);
    logic mag_lt;
    logic mag_gt;
    logic both_zero;

    always_comb begin
        mag_lt    = a_i.mag < b_i.mag;
        mag_gt    = a_i.mag > b_i.mag;
        both_zero = a_i.is_zero && b_i.is_zero;
        if (a_i.sign != b_i.sign) begin
            lt_signed_zero_o = a_i.sign;
        end else if (a_i.sign) begin
            lt_signed_zero_o = mag_gt;
        end else begin
            lt_signed_zero_o = mag_lt;
        end
        lt_o = lt_signed_zero_o && !both_zero;
        eq_o = both_zero || ((a_i.sign == b_i.sign) && (a_i.mag == b_i.mag));
    end
endmodule

// File: rtl/fpd_sign_inject.sv
module fpd_sign_inject
    import fpd_cmsj_pkg::*;
#(
    parameter int unsigned W = FP_W
) (
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] a_i,
    input  logic         sign_b_i,
    output logic [W-1:0] res_o
);
    logic new_sign;

    always_comb begin
        unique case (mode_i)
            2'd1:    new_sign = ~sign_b_i;
            2'd2:    new_sign = a_i[W-1] ^ sign_b_i;
            default: new_sign = sign_b_i;
        endcase
        res_o = {new_sign, a_i[W-2:0]};
    end
endmodule

// File: rtl/fpd_cmsj_unit.sv
module fpd_cmsj_unit
    import fpd_cmsj_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [2:0]        op_sel_i,
    input  logic [FP_W-1:0]   opnd_a_i,
    input  logic [FP_W-1:0]   opnd_b_i,
    output logic              done_o,
    output logic [FP_W-1:0]   res_o,
    output logic [FLAG_W-1:0] fflags_o
);
    localparam int unsigned N_OPND = 2;

    fpd_cls_t        cls [N_OPND];
    logic [FP_W-1:0] opnd [N_OPND];
    logic            ord_eq;
    logic            ord_lt;
    logic            ord_lt_sz;
    logic [FP_W-1:0] inj_res;
    fpd_out_t        st_d;
    fpd_out_t        st_q;

    assign opnd[0] = opnd_a_i;
    assign opnd[1] = opnd_b_i;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        fpd_classify #(.E_W(EXP_W), .M_W(MAN_W)) i_cls (
            .val_i (opnd[g]),
            .cls_o (cls[g])
        );
    end

    fpd_order i_order (
        .a_i              (cls[0]),
        .b_i              (cls[1]),
        .eq_o             (ord_eq),
        .lt_o             (ord_lt),
        .lt_signed_zero_o (ord_lt_sz)
    );

    fpd_sign_inject #(.W(FP_W)) i_inject (
        .mode_i   (op_sel_i[1:0] - 2'd1),
        .a_i      (opnd_a_i),
        .sign_b_i (cls[1].sign),
        .res_o    (inj_res)
    );

    always_comb begin
        logic    any_nan;
        logic    any_snan;
        logic    nv;
        logic [FP_W-1:0] r;
        fpd_op_e op;

        op       = fpd_op_e'(op_sel_i);
        any_nan  = cls[0].is_nan || cls[1].is_nan;
        any_snan = cls[0].is_snan || cls[1].is_snan;
        nv       = 1'b0;
        r        = '0;

        unique case (op)
            OP_EQ: begin
                r[0] = ord_eq && !any_nan;
                nv   = any_snan;
            end
            OP_LT: begin
                r[0] = ord_lt && !any_nan;
                nv   = any_nan;
            end
            OP_LE: begin
                r[0] = (ord_lt || ord_eq) && !any_nan;
                nv   = any_nan;
            end
            OP_MIN, OP_MAX: begin
                nv = any_snan;
                if (cls[0].is_nan && cls[1].is_nan) begin
                    r = CANON_QNAN;
                end else if (cls[0].is_nan) begin
                    r = opnd_b_i;
                end else if (cls[1].is_nan) begin
                    r = opnd_a_i;
                end else if ((op == OP_MIN) == ord_lt_sz) begin
                    r = opnd_a_i;
                end else begin
                    r = opnd_b_i;
                end
            end
            default: begin
                r = inj_res;
            end
        endcase

        st_d      = st_q;
        st_d.done = req_valid_i;
        if (req_valid_i) begin
            st_d.res   = r;
            st_d.flags = '0;
            st_d.flags[NV_BIT] = nv;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign res_o    = st_q.res;
    assign fflags_o = st_q.flags;
endmodule

// File: rtl/fpd_cmsj_unit_chk.sv
module fpd_cmsj_unit_chk
    import fpd_cmsj_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic [2:0]        op_sel_i,
    input logic [FP_W-1:0]   opnd_a_i,
    input logic [FP_W-1:0]   opnd_b_i,
    input logic              done_o,
    input logic [FP_W-1:0]   res_o,
    input logic [FLAG_W-1:0] fflags_o
);
    a_r1_done_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> done_o);

    a_r1_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !done_o);

    a_r1_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> ($stable(res_o) && $stable(fflags_o)));

    a_r2_cmp_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && op_sel_i <= 3'd2) |=> (res_o[FP_W-1:1] == '0));

    a_r8_minmax_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && (op_sel_i == 3'd3 || op_sel_i == 3'd4)) |=>
        (res_o == $past(opnd_a_i) || res_o == $past(opnd_b_i) || res_o == CANON_QNAN));

    a_r10_inject_keeps_mag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && op_sel_i >= 3'd5) |=>
        (res_o[FP_W-2:0] == $past(opnd_a_i[FP_W-2:0]) && fflags_o == '0));

    a_r11_only_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fflags_o[NV_BIT-1:0] == '0);
endmodule

bind fpd_cmsj_unit fpd_cmsj_unit_chk i_fpd_cmsj_unit_chk (.*);

// File: tb/test_fpd_cmsj_unit.sv
`timescale 1ns/1ps
module test_fpd_cmsj_unit;
    localparam logic [63:0] P_ONE   = 64'h3FF0000000000000;
    localparam logic [63:0] P_2P5   = 64'h4004000000000000;
    localparam logic [63:0] P_3     = 64'h4008000000000000;
    localparam logic [63:0] N_ONE   = 64'hBFF0000000000000;
    localparam logic [63:0] N_1P5   = 64'hBFF8000000000000;
    localparam logic [63:0] N_2     = 64'hC000000000000000;
    localparam logic [63:0] N_3     = 64'hC008000000000000;
    localparam logic [63:0] P_INF   = 64'h7FF0000000000000;
    localparam logic [63:0] N_INF   = 64'hFFF0000000000000;
    localparam logic [63:0] P_ZERO  = 64'h0000000000000000;
    localparam logic [63:0] N_ZERO  = 64'h8000000000000000;
    localparam logic [63:0] QNAN    = 64'h7FF8000000000000;
    localparam logic [63:0] QNAN_N  = 64'hFFF8000000000123;
    localparam logic [63:0] SNAN    = 64'h7FF0000000000001;
    localparam logic [4:0]  NV      = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        done;
    logic [63:0] res;
    logic [4:0]  fflags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fpd_cmsj_unit i_fpd_cmsj_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .op_sel_i    (op_sel),
        .opnd_a_i    (opa),
        .opnd_b_i    (opb),
        .done_o      (done),
        .res_o       (res),
        .fflags_o    (fflags)
    );

    task automatic check(input string tag, input logic [63:0] act_r, input logic [63:0] exp_r,
                         input logic [4:0] act_f, input logic [4:0] exp_f);
        n_checks++;
        if (act_r !== exp_r || act_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: result %h flags %h, expected result %h flags %h",
                     tag, act_r, act_f, exp_r, exp_f);
        end
    endtask

    // Issue one request at a falling edge; sample the registered output one cycle later.
    task automatic run_op(input string tag, input logic [2:0] op, input logic [63:0] a,
                          input logic [63:0] b, input logic [63:0] exp_r, input logic [4:0] exp_f);
        @(negedge clk);
        op_sel = op; opa = a; opb = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " done"}, {63'd0, done}, 64'd1, 5'd0, 5'd0);
        check(tag, res, exp_r, fflags, exp_f);
    endtask

    task automatic t_reset;
        check("R1 reset", {63'd0, done} | res, 64'd0, fflags, 5'd0);
    endtask

    task automatic t_cmp_order;
        run_op("R3 eq equal",     3'd0, N_1P5, N_1P5, 64'd1, 5'd0);
        run_op("R3 le equal",     3'd2, N_1P5, N_1P5, 64'd1, 5'd0);
        run_op("R3 lt equal",     3'd1, N_1P5, N_1P5, 64'd0, 5'd0);
        run_op("R3 eq smaller",   3'd0, N_2,   N_1P5, 64'd0, 5'd0);
        run_op("R3 lt neg",       3'd1, N_2,   N_1P5, 64'd1, 5'd0);
        run_op("R3 le neg",       3'd2, N_2,   N_1P5, 64'd1, 5'd0);
        run_op("R3 lt mixed",     3'd1, P_ONE, N_2,   64'd0, 5'd0);
        run_op("R2 lt pos bit0",  3'd1, P_ONE, P_2P5, 64'd1, 5'd0);
        run_op("R3 le greater",   3'd2, P_2P5, P_ONE, 64'd0, 5'd0);
    endtask

    task automatic t_cmp_special;
        run_op("R4 eq -inf",      3'd0, N_INF,  N_INF,  64'd1, 5'd0);
        run_op("R4 lt -inf",      3'd1, N_INF,  N_INF,  64'd0, 5'd0);
        run_op("R4 le +inf",      3'd2, P_INF,  P_INF,  64'd1, 5'd0);
        run_op("R4 eq zeros",     3'd0, P_ZERO, N_ZERO, 64'd1, 5'd0);
        run_op("R4 lt zeros",     3'd1, N_ZERO, P_ZERO, 64'd0, 5'd0);
    endtask

    task automatic t_cmp_nan;
        run_op("R5 eq qnan",      3'd0, QNAN,  P_ONE, 64'd0, 5'd0);
        run_op("R5 eq snan",      3'd0, P_ONE, SNAN,  64'd0, NV);
        run_op("R5 lt qnan",      3'd1, QNAN,  P_ONE, 64'd0, NV);
        run_op("R5 le qnan",      3'd2, P_ONE, QNAN,  64'd0, NV);
    endtask

    task automatic t_minmax;
        run_op("R6 min pos",      3'd3, P_2P5, P_ONE, P_ONE, 5'd0);
        run_op("R6 max pos",      3'd4, P_2P5, P_ONE, P_2P5, 5'd0);
        run_op("R6 min neg",      3'd3, N_1P5, N_2,   N_2,   5'd0);
        run_op("R6 max neg",      3'd4, N_2,   N_1P5, N_1P5, 5'd0);
        run_op("R7 min qnan a",   3'd3, QNAN,  N_2,   N_2,   5'd0);
        run_op("R7 max qnan b",   3'd4, P_ONE, QNAN_N, P_ONE, 5'd0);
        run_op("R7 min snan",     3'd3, SNAN,  P_ONE, P_ONE, NV);
        run_op("R8 min two nan",  3'd3, QNAN_N, SNAN, QNAN,  NV);
        run_op("R8 max two qnan", 3'd4, QNAN_N, QNAN_N, QNAN, 5'd0);
        run_op("R9 min zeros",    3'd3, P_ZERO, N_ZERO, N_ZERO, 5'd0);
        run_op("R9 max zeros",    3'd4, N_ZERO, P_ZERO, P_ZERO, 5'd0);
    endtask

    task automatic t_inject;
        run_op("R10 sgn",         3'd5, P_3,  N_ONE, N_3,  5'd0);
        run_op("R10 sgnn",        3'd6, P_3,  N_ONE, P_3,  5'd0);
        run_op("R10 sgnn pos b",  3'd6, N_3,  P_2P5, N_3,  5'd0);
        run_op("R10 sgnx",        3'd7, N_3,  N_2,   P_3,  5'd0);
        run_op("R10 sgn snan",    3'd5, SNAN, N_ONE, 64'hFFF0000000000001, 5'd0);
    endtask

    // R1: outputs hold with no request; R11 flags keep bits 3:0 clear.
    task automatic t_hold;
        run_op("R11 flag order",  3'd1, SNAN, P_ONE, 64'd0, NV);
        @(negedge clk);
        op_sel = 3'd4; opa = P_3; opb = N_3; req_valid = 1'b0;
        @(negedge clk);
        check("R1 no done", {63'd0, done}, 64'd0, 5'd0, 5'd0);
        check("R1 hold", res, 64'd0, fflags, NV);
        run_op("R1 back to back a", 3'd4, P_3, N_3, P_3, 5'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cmp_order();
        t_cmp_special();
        t_cmp_nan();
        t_minmax();
        t_inject();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule